// File: doc/BRIEF.md
# Double-Buffered Interrupt Status Bank

This block holds the second-level interrupt event bits for a set of banks. Each bank has a width that is a parameter; the default is two banks of 32 bits. Event sources pulse one input bit per event. Software reads a bank through a register port. A read that returns a nonzero value freezes the bank. Until software has cleared every bit of the frozen value, the bits it sees do not change. Events that arrive during that time collect in a shadow store.

Software clears bits by writing ones to them. A clear of a bit takes effect only after a selector/identity stage has reported that bit as serviced. When the last frozen bit is cleared, the bank unfreezes. In that same cycle the shadow contents, together with any events arriving in that cycle, become the visible value. A per-bank pending output feeds a master control register.

Top module: `irq_dbuf_status`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) empties the visible and shadow stores of every bank, clears every serviced flag and unfreezes every bank. After reset, reads return 0 and `pend_o` is 0.
- R2: A read of bank `rd_bank_i` (with `rd_en_i` high at an edge) places that bank's visible value on `rd_data_o` after that edge. If the value is nonzero, the bank freezes.
- R3: While a bank is frozen and no effective clear happens, its visible value stays unchanged. New events go to the shadow store.
- R4: A read that returns zero does not freeze the bank. Later events appear in the visible value directly.
- R5: Clearing is write-one-to-clear per bit. A clear that leaves some frozen bits set keeps the bank frozen, and shadowed events stay hidden.
- R6: A write-one to a bit whose serviced flag is not set leaves that bit set.
- R7: Bit b of `pend_o` is 1 exactly when bank b has a nonzero visible value. It changes at the same edge as the visible value.
- R8: The clear that empties the frozen value unfreezes the bank. The visible value becomes the shadow store OR the events of that same cycle, and the shadow store is emptied.
- R9: A service strobe (`svc_en_i`, `svc_bank_i`, `svc_bit_i`) sets the serviced flag of one bit. An effective clear of that bit resets the flag, so a later clear of the same bit needs a new service.
- R10: Repeated events on one bit while the bank is frozen merge into a single shadow bit.
- R11: Banks are independent. Reads, clears, events and service strobes on one bank leave every other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | NB*W | Event pulses; bank b uses bits b*W+W-1..b*W |
| rd_en_i | input | 1 | Register read strobe |
| rd_bank_i | input | BANK_W | Bank selected for the read |
| rd_data_o | output | W | Registered read data |
| wr_en_i | input | 1 | Write-one-to-clear strobe |
| wr_bank_i | input | BANK_W | Bank selected for the clear |
| wr_data_i | input | W | Mask of bits to clear |
| svc_en_i | input | 1 | Selector/identity serviced strobe |
| svc_bank_i | input | BANK_W | Bank of the serviced bit |
| svc_bit_i | input | BIT_W | Index of the serviced bit |
| pend_o | output | NB | Registered per-bank pending summary |

## Verification
Every bit of both banks goes through the same cycle: raise the bit, read it to freeze the bank, try a clear without service, then service and clear. This separates the service gate from the clear path at every bit position. Directed sequences cover a single event and a repeated event while frozen, which distinguishes merging from losing a bit. They also cover a partial clear against a full clear, which shows whether the freeze is released too early. An event in the same cycle as the final clear checks the merge edge. A read of an empty bank checks that no freeze occurs. Activity on one bank is checked against the other bank's value and serviced flags, and a reset taken with serviced flags set checks that the flags are cleared.

// File: rtl/irq_dbuf_pkg.sv
package irq_dbuf_pkg;

  typedef enum logic {
    HOLD_OPEN = 1'b0,
    HOLD_HELD = 1'b1
  } hold_e;

endpackage

// File: rtl/irq_svc_flags.sv
module irq_svc_flags #(
  parameter int W     = 32,
  parameter int BIT_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en_i,
  input  logic [BIT_W-1:0] set_bit_i,
  input  logic [W-1:0]     consume_i,
  output logic [W-1:0]     flag_o
);

  logic [W-1:0] set_vec;
  logic [W-1:0] flag_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_dec
      assign set_vec[i] = set_en_i && (set_bit_i == BIT_W'(i));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
    end else begin
      flag_q <= (flag_q & ~consume_i) | set_vec;
    end
  end

  assign flag_o = flag_q;

  AST_SVC_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    set_en_i |=> ((flag_q & $past(set_vec)) == $past(set_vec))); // R9

  AST_CONSUME_DROPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (|(consume_i & ~set_vec)) |=> ((flag_q & $past(consume_i & ~set_vec)) == '0)); // R9

endmodule

// File: rtl/irq_bank_store.sv
module irq_bank_store
  import irq_dbuf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic         rd_i,
  input  logic [W-1:0] clr_req_i,
  input  logic [W-1:0] svc_flag_i,
  output logic [W-1:0] clr_eff_o,
  output logic [W-1:0] vis_o,
  output logic         pend_o
);

  logic [W-1:0] vis_q, vis_n;
  logic [W-1:0] shd_q, shd_n;
  hold_e        hold_q, hold_n;
  logic         pend_q;
  logic [W-1:0] clr_eff;
  logic [W-1:0] vis_cl;

  assign clr_eff = clr_req_i & svc_flag_i & vis_q;
  assign vis_cl  = vis_q & ~clr_eff;

  always_comb begin
    vis_n  = vis_q;
    shd_n  = shd_q;
    hold_n = hold_q;
    if (hold_q == HOLD_OPEN) begin
      if (rd_i && (|vis_cl)) begin
        hold_n = HOLD_HELD;
        vis_n  = vis_cl;
        shd_n  = evt_i;
      end else begin
        vis_n  = vis_cl | evt_i;
        shd_n  = '0;
      end
    end else begin
      if (vis_cl == '0) begin
        hold_n = HOLD_OPEN;
        vis_n  = shd_q | evt_i;
        shd_n  = '0;
      end else begin
        vis_n  = vis_cl;
        shd_n  = shd_q | evt_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vis_q  <= '0;
      shd_q  <= '0;
      hold_q <= HOLD_OPEN;
      pend_q <= 1'b0;
    end else begin
      vis_q  <= vis_n;
      shd_q  <= shd_n;
      hold_q <= hold_n;
      pend_q <= |vis_n;
    end
  end

  assign clr_eff_o = clr_eff;
  assign vis_o     = vis_q;
  assign pend_o    = pend_q;

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (hold_q == HOLD_HELD && clr_eff == '0) |=> (vis_q == $past(vis_q))); // R3

  AST_OPEN_SHADOW_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (hold_q == HOLD_OPEN) |-> (shd_q == '0)); // R8

  AST_ZERO_READ_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (hold_q == HOLD_OPEN && rd_i && vis_q == '0) |=> (hold_q == HOLD_OPEN)); // R4

  AST_UNSERVICED_KEEPS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (hold_q == HOLD_HELD && (vis_q & ~svc_flag_i) != '0) |=> (hold_q == HOLD_HELD)); // R6

  AST_NONZERO_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (rd_i && clr_req_i == '0 && vis_q != '0) |=> (hold_q == HOLD_HELD)); // R2

  AST_HELD_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    (hold_q == HOLD_HELD) |-> (vis_q != '0)); // R5

endmodule

// File: rtl/irq_dbuf_status.sv
module irq_dbuf_status #(
  parameter int NB     = 2,
  parameter int W      = 32,
  parameter int BANK_W = (NB > 1) ? $clog2(NB) : 1,
  parameter int BIT_W  = (W > 1) ? $clog2(W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NB*W-1:0]   evt_i,
  input  logic              rd_en_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  output logic [W-1:0]      rd_data_o,
  input  logic              wr_en_i,
  input  logic [BANK_W-1:0] wr_bank_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic              svc_en_i,
  input  logic [BANK_W-1:0] svc_bank_i,
  input  logic [BIT_W-1:0]  svc_bit_i,
  output logic [NB-1:0]     pend_o
);

  logic [W-1:0] vis     [NB];
  logic [W-1:0] clr_eff [NB];
  logic [W-1:0] flags   [NB];
  logic [NB-1:0] pend_w;
  logic [W-1:0] rd_data_q;

  generate
    for (genvar b = 0; b < NB; b++) begin : g_bank
      logic         rd_hit;
      logic         svc_hit;
      logic [W-1:0] clr_req;

      assign rd_hit  = rd_en_i && (rd_bank_i == BANK_W'(b));
      assign svc_hit = svc_en_i && (svc_bank_i == BANK_W'(b));
      assign clr_req = (wr_en_i && (wr_bank_i == BANK_W'(b))) ? wr_data_i : '0;

      irq_svc_flags #(.W(W), .BIT_W(BIT_W)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .set_en_i  (svc_hit),
        .set_bit_i (svc_bit_i),
        .consume_i (clr_eff[b]),
        .flag_o    (flags[b])
      );

      irq_bank_store #(.W(W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt_i[b*W +: W]),
        .rd_i       (rd_hit),
        .clr_req_i  (clr_req),
        .svc_flag_i (flags[b]),
        .clr_eff_o  (clr_eff[b]),
        .vis_o      (vis[b]),
        .pend_o     (pend_w[b])
      );

      AST_PEND_MATCHES: assert property (@(posedge clk) disable iff (rst)
        pend_w[b] == (vis[b] != '0)); // R7

      AST_CLEAR_IDLE_BANK: assert property (@(posedge clk) disable iff (rst)
        (clr_req == '0) |-> (clr_eff[b] == '0)); // R11
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_q <= '0;
    end else if (rd_en_i) begin
      rd_data_q <= vis[rd_bank_i];
    end
  end

  assign rd_data_o = rd_data_q;
  assign pend_o    = pend_w;

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (pend_o == '0 && rd_data_o == '0)); // R1

endmodule

// File: tb/tb_irq_dbuf_status.sv
module tb_irq_dbuf_status;

  localparam int NB = 2;
  localparam int W  = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NB*W-1:0] evt = '0;
  logic          rd_en = 1'b0;
  logic [0:0]    rd_bank = '0;
  logic [W-1:0]  rd_data;
  logic          wr_en = 1'b0;
  logic [0:0]    wr_bank = '0;
  logic [W-1:0]  wr_data = '0;
  logic          svc_en = 1'b0;
  logic [0:0]    svc_bank = '0;
  logic [4:0]    svc_bit = '0;
  logic [NB-1:0] pend;

  int n_cmp = 0;
  int n_bad = 0;

  irq_dbuf_status #(.NB(NB), .W(W)) dut (
    .clk(clk), .rst(rst), .evt_i(evt),
    .rd_en_i(rd_en), .rd_bank_i(rd_bank), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_bank_i(wr_bank), .wr_data_i(wr_data),
    .svc_en_i(svc_en), .svc_bank_i(svc_bank), .svc_bit_i(svc_bit),
    .pend_o(pend)
  );

  always #10 clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic ev(int bk, logic [W-1:0] m);
    evt = '0;
    evt[bk*W +: W] = m;
    step();
    evt = '0;
  endtask

  task automatic rdv(int bk, output logic [W-1:0] d);
    rd_en = 1'b1;
    rd_bank = bk[0];
    step();
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic clr(int bk, logic [W-1:0] m);
    wr_en = 1'b1;
    wr_bank = bk[0];
    wr_data = m;
    step();
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic sv(int bk, int bt);
    svc_en = 1'b1;
    svc_bank = bk[0];
    svc_bit = bt[4:0];
    step();
    svc_en = 1'b0;
  endtask

  initial begin
    step();
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] d;
    step(); step();
    rst = 1'b0;
    step();
    check("R1 rd_data after reset", rd_data, '0);
    check("R1 pend after reset", {30'd0, pend}, '0);
    rdv(0, d);
    check("R1 bank0 empty", d, '0);

    // freeze, shadow, duplicate merge, unfreeze
    ev(0, 32'h8);
    check("R7 pend rises", {30'd0, pend}, 32'h1);
    rdv(0, d);
    check("R2 read value", d, 32'h8);
    ev(0, 32'h20);
    rdv(0, d);
    check("R3 frozen value", d, 32'h8);
    ev(0, 32'h20);
    sv(0, 3);
    clr(0, 32'h8);
    check("R7 pend stays with shadow", {30'd0, pend}, 32'h1);
    rdv(0, d);
    check("R8 R10 shadow merged once", d, 32'h20);

    // service gate
    clr(0, 32'h20);
    rdv(0, d);
    check("R6 unserviced clear ignored", d, 32'h20);
    sv(0, 5);
    clr(0, 32'h20);
    check("R7 pend falls", {30'd0, pend}, '0);
    rdv(0, d);
    check("R4 zero read", d, '0);
    ev(0, 32'h2);
    rdv(0, d);
    check("R4 event after zero read visible", d, 32'h2);

    // partial clear and same-cycle merge
    ev(0, 32'h1);
    sv(0, 1);
    clr(0, 32'h2);
    ev(0, 32'h10);
    rdv(0, d);
    check("R8 merge then direct event", d, 32'h11);
    ev(0, 32'h100);
    sv(0, 0);
    sv(0, 4);
    clr(0, 32'h1);
    rdv(0, d);
    check("R5 partial clear keeps freeze", d, 32'h10);
    wr_en = 1'b1; wr_bank = 1'b0; wr_data = 32'h10;
    evt = '0; evt[9] = 1'b1;
    step();
    wr_en = 1'b0; wr_data = '0; evt = '0;
    rdv(0, d);
    check("R8 same-cycle event merged", d, 32'h300);

    // serviced flag consumed
    sv(0, 8);
    sv(0, 9);
    clr(0, 32'h300);
    ev(0, 32'h10);
    rdv(0, d);
    check("R9 event re-raised", d, 32'h10);
    clr(0, 32'h10);
    rdv(0, d);
    check("R9 flag consumed by earlier clear", d, 32'h10);
    sv(0, 4);
    clr(0, 32'h10);
    rdv(0, d);
    check("R9 cleared after new service", d, '0);

    // bank independence
    ev(0, 32'h40);
    rdv(0, d);
    ev(1, 32'h40);
    rdv(1, d);
    check("R11 bank1 direct", d, 32'h40);
    check("R11 both pending", {30'd0, pend}, 32'h3);
    sv(1, 6);
    clr(0, 32'h40);
    rdv(0, d);
    check("R11 other-bank service ignored", d, 32'h40);
    clr(1, 32'h40);
    rdv(1, d);
    check("R11 bank1 cleared", d, '0);
    sv(0, 6);
    clr(0, 32'h40);
    check("R11 none pending", {30'd0, pend}, '0);

    // sweep every bit of every bank
    for (int bk = 0; bk < NB; bk++) begin
      for (int b = 0; b < W; b++) begin
        ev(bk, 32'h1 << b);
        rdv(bk, d);
        check("R2 sweep read", d, 32'h1 << b);
        clr(bk, 32'h1 << b);
        rdv(bk, d);
        check("R6 sweep gate", d, 32'h1 << b);
        sv(bk, b);
        clr(bk, 32'h1 << b);
        rdv(bk, d);
        check("R5 sweep clear", d, '0);
        check("R7 sweep pend", {30'd0, pend}, '0);
      end
    end

    // reset drops serviced flags and frozen state
    sv(0, 2);
    ev(0, 32'h1);
    rdv(0, d);
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R1 pend after mid reset", {30'd0, pend}, '0);
    rdv(0, d);
    check("R1 store empty after reset", d, '0);
    ev(0, 32'h4);
    rdv(0, d);
    clr(0, 32'h4);
    rdv(0, d);
    check("R1 flags cleared by reset", d, 32'h4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule